// File: doc/BRIEF.md
# DSSS Differential Barker Spreader

This block is the low-rate transmit spreader of a direct-sequence spread-spectrum baseband. It takes already-scrambled data one symbol at a time. At the 1 Mbps setting a symbol holds one bit and is sent as differential BPSK. At the 2 Mbps setting a symbol holds two bits and is sent as differential QPSK. The block keeps a two-bit carrier quadrant and adds each symbol's phase step to it. It then sends that quadrant's I/Q sign pair over eleven Barker chips, one chip per clock.

A packet starts when `tx_en` is high while the rate field names one of the two low rates. At that point the quadrant register loads `start_phase`. The block asks for each symbol with `data_req`. A symbol is taken in any cycle where `data_req`, `data_valid` and the start condition are all true. The two high-rate codes (`10` = 5.5 Mbps and `11` = 11 Mbps) belong to a different datapath, and this block stays idle while either is selected.

The control is a three-state machine:
- S_IDLE: no chips and no request.
- S_FETCH: waiting for a symbol, with the request raised and no chips.
- S_SPREAD: sending the eleven chips of the current symbol.

Its transitions are:
- IDLE→FETCH: start condition true.
- FETCH→SPREAD: symbol taken.
- FETCH→IDLE: `tx_en` low or a high-rate code selected.
- SPREAD→SPREAD: last chip and a new symbol taken.
- SPREAD→FETCH: last chip and no data.
- SPREAD→IDLE: last chip and the start condition false.

Top module: `dsss_barker_spreader`

## Requirements
- R1: While reset is held and after it is released, with `tx_en` low, `chip_valid` and `data_req` are 0.
- R2: In idle, `tx_en`=1 with `rate_sel` 00 or 01 loads `start_phase` into the quadrant register. From the next cycle `data_req`=1 and `chip_valid`=0 until a symbol is taken.
- R3: A symbol taken at a clock edge yields exactly 11 consecutive cycles with `chip_valid`=1. The first of these cycles follows that edge, and chip index 0 comes first.
- R4: Chip k of a symbol at quadrant 0 follows the Barker pattern +1 -1 +1 +1 -1 +1 +1 +1 -1 -1 -1 (k = 0..10). A +1 chip is sent as logic 0 on both `chip_i` and `chip_q`.
- R5: Quadrant q multiplies the Barker chip by an I/Q sign pair:
  - q=0 (0°): (+,+)
  - q=1 (90°): (−,+)
  - q=2 (180°): (−,−)
  - q=3 (270°): (+,−)
- R6: At `rate_sel`=00 the quadrant steps by 0 when `data_in[0]`=0 and by 2 (180°) when `data_in[0]`=1. `data_in[1]` has no effect.
- R7: At `rate_sel`=01 the bit in `data_in[0]` is sent first and the bit in `data_in[1]` second. The quadrant steps by:
  - 0 for first/second = 00
  - 1 for 01
  - 2 for 11
  - 3 for 10
- R8: During a symbol, `data_req` is 1 only on chip 10. If data is offered then, chip 0 of the next symbol follows with no gap.
- R9: When `data_req`=1 and `data_valid`=0, the next cycle has `chip_valid`=0. The quadrant does not change while the block waits.
- R10: With `rate_sel` 10 or 11, or with `tx_en` low, no packet starts. If either holds on chip 10 or while waiting, the block returns to idle (`chip_valid`=0, `data_req`=0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Chip clock, one chip per rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Packet enable; low ends the packet at a symbol boundary |
| rate_sel | input | 2 | Rate field: 00 = 1 Mbps, 01 = 2 Mbps, 10/11 = high rates (idle here) |
| start_phase | input | 2 | Quadrant loaded at packet start |
| data_valid | input | 1 | A symbol is present on `data_in` |
| data_in | input | 2 | Symbol bits; bit 0 is the first bit |
| data_req | output | 1 | Request for the next symbol |
| chip_valid | output | 1 | `chip_i`/`chip_q` carry a chip |
| chip_i | output | 1 | In-phase chip sign (0 = +1) |
| chip_q | output | 1 | Quadrature chip sign (0 = +1) |

## Verification
The assertions take the following for granted about the inputs:
- `data_in` is meaningful only in the cycle where a symbol is taken.
- `rate_sel` and `tx_en` change only at negative clock edges, so every transition is seen whole by the next rising edge.

The stimulus drives every input on the falling edge. It offers data only while `data_req` is high, and it changes the rate or drops `tx_en` only on chip 10 or while waiting. Each packet therefore ends at a symbol boundary, and the phase checks compare against quadrants the bench has computed itself.

// File: rtl/dsss_pkg.sv
package dsss_pkg;

    typedef enum logic [1:0] {
        RATE_1M  = 2'b00,
        RATE_2M  = 2'b01,
        RATE_5M5 = 2'b10,
        RATE_11M = 2'b11
    } rate_e;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_FETCH  = 2'd1,
        S_SPREAD = 2'd2
    } fsm_e;

    typedef logic [1:0] quad_t;

    // Phase step per symbol: one bit as 0/180 degrees, or a Gray-coded dibit.
    function automatic quad_t phase_step(input logic qpsk, input logic [1:0] bits);
        quad_t step;
        if (qpsk) begin
            step = {bits[0], bits[0] ^ bits[1]};
        end else begin
            step = {bits[0], 1'b0};
        end
        return step;
    endfunction

endpackage

// File: rtl/dsss_phase_acc.sv
module dsss_phase_acc
    import dsss_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  quad_t      start_q,
    input  logic       advance,
    input  logic       qpsk,
    input  logic [1:0] sym_bits,
    output quad_t      phase_q
);

    quad_t phase_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_r <= '0;
        end else if (load) begin
            phase_r <= start_q;
        end else if (advance) begin
            phase_r <= phase_r + phase_step(qpsk, sym_bits);
        end
    end

    assign phase_q = phase_r;

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !advance) |=> $stable(phase_r)); // R9
    AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (phase_r == $past(start_q))); // R2

endmodule

// File: rtl/dsss_chip_seq.sv
module dsss_chip_seq #(
    parameter int          N_CHIPS = 11,
    parameter logic [N_CHIPS-1:0] CODE = 11'b11100010010,
    localparam int         CNT_W   = $clog2(N_CHIPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    output logic [CNT_W-1:0] idx,
    output logic             last,
    output logic             code_bit
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(N_CHIPS - 1);

    logic [CNT_W-1:0] cnt_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_r <= '0;
        end else if (restart) begin
            cnt_r <= '0;
        end else if (run && (cnt_r != LAST_IDX)) begin
            cnt_r <= cnt_r + 1'b1;
        end
    end

    assign idx      = cnt_r;
    assign last     = (cnt_r == LAST_IDX);
    assign code_bit = CODE[cnt_r];

    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_r == '0)); // R3

endmodule

// File: rtl/dsss_chip_map.sv
module dsss_chip_map
    import dsss_pkg::*;
(
    input  quad_t phase,
    input  logic  code_bit,
    output logic  chip_i,
    output logic  chip_q
);

    logic neg_i;
    logic neg_q;

    // Quadrant q sits at 45 + 90*q degrees: I negative in quadrants 1,2; Q negative in 2,3.
    always_comb begin
        neg_i  = phase[1] ^ phase[0];
        neg_q  = phase[1];
        chip_i = code_bit ^ neg_i;
        chip_q = code_bit ^ neg_q;
    end

endmodule

// File: rtl/dsss_barker_spreader.sv
module dsss_barker_spreader
    import dsss_pkg::*;
#(
    parameter int                 N_CHIPS = 11,
    parameter logic [N_CHIPS-1:0] CODE    = 11'b11100010010,
    localparam int                CNT_W   = $clog2(N_CHIPS)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_en,
    input  logic [1:0] rate_sel,
    input  logic [1:0] start_phase,
    input  logic       data_valid,
    input  logic [1:0] data_in,
    output logic       data_req,
    output logic       chip_valid,
    output logic       chip_i,
    output logic       chip_q
);

    fsm_e             state_q;
    fsm_e             state_d;
    logic             low_rate;
    logic             go;
    logic             accept;
    logic             load;
    logic             last;
    logic             code_bit;
    logic [CNT_W-1:0] idx;
    quad_t            phase;

    assign low_rate = (rate_sel == RATE_1M) || (rate_sel == RATE_2M);
    assign go       = tx_en && low_rate;
    assign accept   = data_req && data_valid && go;
    assign load     = (state_q == S_IDLE) && go;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (go) state_d = S_FETCH;
            end
            S_FETCH: begin
                if (!go)             state_d = S_IDLE;
                else if (data_valid) state_d = S_SPREAD;
            end
            S_SPREAD: begin
                if (last) begin
                    if (!go)             state_d = S_IDLE;
                    else if (data_valid) state_d = S_SPREAD;
                    else                 state_d = S_FETCH;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Output logic
    always_comb begin
        data_req   = 1'b0;
        chip_valid = 1'b0;
        unique case (state_q)
            S_IDLE:   ;
            S_FETCH:  data_req = 1'b1;
            S_SPREAD: begin
                chip_valid = 1'b1;
                data_req   = last;
            end
            default:  ;
        endcase
    end

    dsss_phase_acc u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .start_q  (start_phase),
        .advance  (accept),
        .qpsk     (rate_sel == RATE_2M),
        .sym_bits (data_in),
        .phase_q  (phase)
    );

    dsss_chip_seq #(
        .N_CHIPS (N_CHIPS),
        .CODE    (CODE)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (accept),
        .run      (state_q == S_SPREAD),
        .idx      (idx),
        .last     (last),
        .code_bit (code_bit)
    );

    dsss_chip_map u_map (
        .phase    (phase),
        .code_bit (code_bit),
        .chip_i   (chip_i),
        .chip_q   (chip_q)
    );

    AST_STALL_NO_CHIP: assert property (@(posedge clk) disable iff (!rst_n)
        (data_req && !data_valid) |=> !chip_valid); // R9
    AST_FIRST_CHIP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chip_valid) |-> (idx == '0)); // R3
    AST_REQ_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (data_req && chip_valid) |-> (idx == CNT_W'(N_CHIPS - 1))); // R8
    AST_HIGH_RATE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_IDLE) && !low_rate) |=> (!chip_valid && !data_req)); // R10
    AST_DBPSK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (rate_sel == RATE_1M)) |=>
        (phase == quad_t'($past(phase) + {$past(data_in[0]), 1'b0}))); // R6

endmodule

// File: tb/dsss_barker_spreader_tb_top.sv
`timescale 1ns/1ps
module dsss_barker_spreader_tb_top;

    localparam logic [10:0] BARK = 11'b11100010010; // bit k = chip k, 1 = -1

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic [1:0] rate_sel = 2'b00;
    logic [1:0] start_phase = 2'b00;
    logic       data_valid = 1'b0;
    logic [1:0] data_in = 2'b00;
    logic       data_req;
    logic       chip_valid;
    logic       chip_i;
    logic       chip_q;

    int n_total = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    dsss_barker_spreader dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_en       (tx_en),
        .rate_sel    (rate_sel),
        .start_phase (start_phase),
        .data_valid  (data_valid),
        .data_in     (data_in),
        .data_req    (data_req),
        .chip_valid  (chip_valid),
        .chip_i      (chip_i),
        .chip_q      (chip_q)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
        end
    endtask

    function automatic logic [1:0] next_ph(input logic [1:0] ph, input logic [1:0] rate,
                                           input logic [1:0] d);
        logic [1:0] inc;
        if (rate == 2'b00) begin
            inc = d[0] ? 2'd2 : 2'd0;
        end else begin
            case (d) // d[0] first bit, d[1] second bit
                2'b00:   inc = 2'd0;
                2'b10:   inc = 2'd1;
                2'b11:   inc = 2'd2;
                default: inc = 2'd3;
            endcase
        end
        return ph + inc;
    endfunction

    function automatic logic [1:0] exp_chip(input int k, input logic [1:0] ph);
        logic b;
        logic ni;
        logic nq;
        b  = BARK[k];
        ni = (ph == 2'd1) || (ph == 2'd2);
        nq = (ph == 2'd2) || (ph == 2'd3);
        return {b ^ ni, b ^ nq};
    endfunction

    // One packet: n symbols from syms (2 bits each), optional 3-cycle stall after symbol stall_at.
    task automatic run_packet(input string tag, input logic [1:0] rate, input logic [1:0] st,
                              input int n, input logic [15:0] syms, input int stall_at,
                              input bit end_high_rate);
        logic [1:0] ph;
        logic [1:0] d;
        @(negedge clk);
        tx_en = 1'b1; rate_sel = rate; start_phase = st; data_valid = 1'b0;
        @(negedge clk);
        check("R2 request after start", {6'd0, data_req, chip_valid}, 8'b10);
        ph = st;
        for (int s = 0; s < n; s++) begin
            d = syms[2*s +: 2];
            data_valid = 1'b1; data_in = d;
            ph = next_ph(ph, rate, d);
            for (int k = 0; k < 11; k++) begin
                @(negedge clk);
                check({tag, "/R3 chip"}, {5'd0, chip_valid, chip_i, chip_q}, {5'd0, 1'b1, exp_chip(k, ph)});
                check("R8 request timing", {7'd0, data_req}, {7'd0, (k == 10)});
                if (k == 0) data_valid = 1'b0;
            end
            if (s == n - 1) begin
                data_valid = 1'b0;
                if (end_high_rate) rate_sel = 2'b10;
                else               tx_en = 1'b0;
            end else if (s == stall_at) begin
                data_valid = 1'b0;
                for (int w = 0; w < 3; w++) begin
                    @(negedge clk);
                    check("R9 stall", {6'd0, data_req, chip_valid}, 8'b10);
                end
            end
        end
        @(negedge clk);
        check("R10 end of packet", {6'd0, chip_valid, data_req}, 8'b00);
        tx_en = 1'b0; rate_sel = rate;
        @(negedge clk);
    endtask

    task automatic test_reset();
        @(negedge clk);
        check("R1 in reset", {6'd0, chip_valid, data_req}, 8'b00);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 after reset", {6'd0, chip_valid, data_req}, 8'b00);
    endtask

    task automatic test_high_rate_idle();
        for (int r = 2; r < 4; r++) begin
            @(negedge clk);
            rate_sel = 2'(r); tx_en = 1'b1; data_valid = 1'b1;
            for (int c = 0; c < 4; c++) begin
                @(negedge clk);
                check("R10 high rate idle", {6'd0, chip_valid, data_req}, 8'b00);
            end
            tx_en = 1'b0; data_valid = 1'b0;
        end
        rate_sel = 2'b00;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_total++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin : main
        test_reset();
        // R4: quadrant 0, zero data shows the raw Barker pattern
        run_packet("R4", 2'b00, 2'd0, 2, 16'h0000, -1, 1'b0);
        // R5: each start quadrant, zero data
        run_packet("R5", 2'b00, 2'd1, 1, 16'h0000, -1, 1'b0);
        run_packet("R5", 2'b00, 2'd2, 1, 16'h0000, -1, 1'b0);
        run_packet("R5", 2'b00, 2'd3, 1, 16'h0000, -1, 1'b0);
        // R6: DBPSK bits with data_in[1] toggled as noise
        run_packet("R6", 2'b00, 2'd0, 5, {6'd0, 2'b01, 2'b10, 2'b00, 2'b11, 2'b01}, -1, 1'b0);
        // R7: DQPSK all dibits with a stall after the third symbol
        run_packet("R7", 2'b01, 2'd3, 5, {6'd0, 2'b11, 2'b01, 2'b11, 2'b10, 2'b00}, 2, 1'b0);
        // R10: DQPSK packet ended by switching to a high-rate code
        run_packet("R7", 2'b01, 2'd1, 3, {10'd0, 2'b01, 2'b10, 2'b11}, 0, 1'b1);
        test_high_rate_idle();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule